// File: doc/BRIEF.md
# Configurable Multi-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address by reading translation tables from memory one descriptor at a time. A single control word sets how many high address bits are skipped and how wide the index into each of up to four table levels is. A 64-bit root pointer gives the first descriptor. Each descriptor read from memory says, through its type field, whether the walk stops at a page, continues through a table of 4-byte entries, continues through a table of 8-byte entries, or has failed. An 8-byte descriptor can also bound the index allowed at the next level, either from above or from below.

A client presents the logical address, control word and root pointer with a one-cycle `start` pulse. The walker then issues word reads on a simple request/acknowledge port until it reaches a page or an error. It answers with a one-cycle `done` pulse carrying the physical address, the address of the final descriptor and an error flag. The controller has six states. ST_IDLE waits for `start` and goes to ST_DONE at once when translation is off or a mode bit is set; otherwise it goes to ST_EVAL. ST_EVAL judges the current descriptor. It goes to ST_RD_SHORT for a 4-byte table, to ST_RD_HI for an 8-byte table, and to ST_DONE for a page or an error. ST_RD_SHORT returns to ST_EVAL on acknowledge. ST_RD_HI moves on to ST_RD_LO on acknowledge, and ST_RD_LO returns to ST_EVAL. ST_DONE always returns to ST_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: When `ctrl[31]` is 0, the result is `paddr` = `vaddr`, `desc_addr` = 0 and `err` = 0, whatever the other control bits are, and no memory read is made.
- R2: When `ctrl[31]` is 1 and either `ctrl[25]` or `ctrl[24]` is 1, the result has `err` = 1 and no memory read is made.
- R3: The count of skipped high address bits is `ctrl[19:16]`. The index widths of levels 1 to 4 are `ctrl[15:12]`, `ctrl[11:8]`, `ctrl[7:4]` and `ctrl[3:0]`. Each index is taken from the logical address starting just below the bits already used, counting from bit 31 downwards.
- R4: Descriptor bits [1:0] encode the type: 1 = page (walk ends), 2 = pointer to a table of 4-byte entries, 3 = pointer to a table of 8-byte entries, 0 = invalid, which ends the walk with `err` = 1.
- R5: A table's base is the pointer's address word with bits [3:0] forced to 0. The entry address is the base plus the index times 4 (for 4-byte tables) or times 8 (for 8-byte tables). An 8-byte entry is read as its upper word at the entry address, followed by its lower word at entry address + 4.
- R6: The upper word of an 8-byte descriptor carries a limit in bits [31:16] that applies to the next index. If limit bit 15 is 1, an index below limit bits [14:0] is an error. If it is 0, an index above the limit is an error. An index equal to the bound passes. A 4-byte descriptor carries no limit.
- R7: At a page descriptor, where N bits of the address have been used so far (skip count plus all consumed widths), `paddr` takes its top N bits from the descriptor's address word and its remaining low bits from `vaddr`.
- R8: The root pointer is an 8-byte descriptor. `root[63:32]` is its upper word, with the type in bits [33:32] and the limit in bits [63:48] applying to the level-1 index. `root[31:0]` is its address word.
- R9: If the walk needs an index at a level whose width is 0, or after four levels, it ends with `err` = 1.
- R10: `mem_req` stays high with a stable, word-aligned `mem_addr` until `mem_ack`. `done` is high for exactly one cycle per accepted walk. A `start` seen while a walk is in progress is ignored.
- R11: `desc_addr` is the memory address of the page descriptor that ended the walk (for an 8-byte entry, its upper-word address). It is 0 when the root itself is a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Logical address to translate |
| ctrl | input | 32 | Translation control word |
| root | input | 64 | Root descriptor: upper word then address word |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory read acknowledge |
| paddr | output | 32 | Physical address result |
| desc_addr | output | 32 | Address of the final page descriptor |
| err | output | 1 | Walk failed |
| done | output | 1 | One-cycle result strobe |

## Verification
The assertions watch every cycle for the memory handshake rule: the request is held with a steady, word-aligned address until acknowledged. They also check that `done` is a single-cycle pulse that never overlaps a request, and that the two early exits (translation off, forbidden mode bits) finish on the very next cycle with the right result. The address arithmetic can only be shown by the bench's scenarios, driven against a table image in its memory model. This covers index extraction with a skip count, short and long entry scaling, upper and lower limits at their boundaries, page merging at different depths, the zero-width and fourth-level error exits, and a stray start pulse during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_RD_SHORT,
        ST_RD_HI,
        ST_RD_LO,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        DT_INVALID = 2'd0,
        DT_PAGE    = 2'd1,
        DT_SHORT   = 2'd2,
        DT_LONG    = 2'd3
    } desc_type_e;
endpackage

// File: rtl/ptw_index_pick.sv
module ptw_index_pick #(
    parameter int ADDR_W     = 32,
    parameter int WIDTH_BITS = 4,
    parameter int POS_W      = 7,
    localparam int IDX_W     = 2 ** WIDTH_BITS
) (
    input  logic [ADDR_W-1:0]     vaddr,
    input  logic [POS_W-1:0]      pos,
    input  logic [WIDTH_BITS-1:0] width,
    output logic [IDX_W-1:0]      idx
);
    logic [2*ADDR_W-1:0] wide;
    logic [IDX_W-1:0]    window;
    logic [WIDTH_BITS:0] rshift;

    always_comb begin
        wide   = {vaddr, {ADDR_W{1'b0}}} << pos;
        window = wide[2*ADDR_W-1 -: IDX_W];
        rshift = (WIDTH_BITS+1)'(IDX_W) - {1'b0, width};
        idx    = (width == '0) ? '0 : (window >> rshift);
    end
endmodule

// File: rtl/ptw_limit_chk.sv
module ptw_limit_chk #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] limit,
    output logic             bad
);
    logic [IDX_W-1:0] floor_v;

    always_comb begin
        floor_v = {1'b0, limit[IDX_W-2:0]};
        bad     = limit[IDX_W-1] ? (idx < floor_v) : (idx > limit);
    end
endmodule

// File: rtl/ptw_page_merge.sv
module ptw_page_merge #(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 7
) (
    input  logic [ADDR_W-1:0] desc_word,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [POS_W-1:0]  used_bits,
    output logic [ADDR_W-1:0] paddr
);
    logic [ADDR_W-1:0] hi_mask;

    always_comb begin
        hi_mask = ~({ADDR_W{1'b1}} >> used_bits);
        paddr   = (desc_word & hi_mask) | (vaddr & ~hi_mask);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEVELS     = 4,
    parameter int WIDTH_BITS = 4,
    localparam int IDX_W     = 2 ** WIDTH_BITS,
    localparam int POS_W     = $clog2(ADDR_W + IDX_W + LEVELS * IDX_W),
    localparam int LVL_W     = $clog2(LEVELS + 1),
    localparam int LI_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       vaddr,
    input  logic [31:0]       ctrl,
    input  logic [63:0]       root,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic [31:0]       paddr,
    output logic [31:0]       desc_addr,
    output logic              err,
    output logic              done
);
    localparam int EN_BIT   = 31;
    localparam int SUPV_BIT = 25;
    localparam int FCL_BIT  = 24;

    walk_state_e state_q, state_d;
    desc_type_e  typ_q;
    logic [31:0]       va_q, ctrl_q, ptr_q, rd_addr_q, desc_q, paddr_q;
    logic [IDX_W-1:0]  lim_q;
    logic              lim_en_q, err_q;
    logic [POS_W-1:0]  pos_q;
    logic [LVL_W-1:0]  level_q;

    logic [WIDTH_BITS-1:0] lvl_w [LEVELS];
    logic [WIDTH_BITS-1:0] cur_w;
    logic [IDX_W-1:0]      idx;
    logic                  lim_bad, walk_go, skip_walk;
    logic [31:0]           merged, next_addr;

    for (genvar g = 0; g < LEVELS; g++) begin : g_width
        assign lvl_w[g] = ctrl_q[WIDTH_BITS*(LEVELS-g)-1 -: WIDTH_BITS];
    end

    always_comb begin
        cur_w = (level_q < LVL_W'(LEVELS)) ? lvl_w[level_q[LI_W-1:0]] : '0;
        next_addr = {ptr_q[31:4], 4'b0000} +
                    ((typ_q == DT_LONG) ? (32'(idx) << 3) : (32'(idx) << 2));
        walk_go   = ((typ_q == DT_SHORT) || (typ_q == DT_LONG)) &&
                    (cur_w != '0) && !(lim_en_q && lim_bad);
        skip_walk = !ctrl[EN_BIT] || ctrl[SUPV_BIT] || ctrl[FCL_BIT];
    end

    ptw_index_pick #(.ADDR_W(32), .WIDTH_BITS(WIDTH_BITS), .POS_W(POS_W)) i_pick (
        .vaddr(va_q), .pos(pos_q), .width(cur_w), .idx(idx)
    );

    ptw_limit_chk #(.IDX_W(IDX_W)) i_limit (
        .idx(idx), .limit(lim_q), .bad(lim_bad)
    );

    ptw_page_merge #(.ADDR_W(32), .POS_W(POS_W)) i_merge (
        .desc_word(ptr_q), .vaddr(va_q), .used_bits(pos_q), .paddr(merged)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = skip_walk ? ST_DONE : ST_EVAL;
            ST_EVAL:     if (!walk_go)            state_d = ST_DONE;
                         else if (typ_q == DT_LONG) state_d = ST_RD_HI;
                         else                     state_d = ST_RD_SHORT;
            ST_RD_SHORT: if (mem_ack) state_d = ST_EVAL;
            ST_RD_HI:    if (mem_ack) state_d = ST_RD_LO;
            ST_RD_LO:    if (mem_ack) state_d = ST_EVAL;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q <= '0; ctrl_q <= '0; ptr_q <= '0; rd_addr_q <= '0;
            desc_q <= '0; paddr_q <= '0; lim_q <= '0; lim_en_q <= 1'b0;
            err_q <= 1'b0; pos_q <= '0; level_q <= '0; typ_q <= DT_INVALID;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    va_q     <= vaddr;
                    ctrl_q   <= ctrl;
                    typ_q    <= desc_type_e'(root[33:32]);
                    lim_q    <= root[63:64-IDX_W];
                    lim_en_q <= 1'b1;
                    ptr_q    <= root[31:0];
                    pos_q    <= POS_W'(ctrl[WIDTH_BITS*LEVELS +: WIDTH_BITS]);
                    level_q  <= '0;
                    desc_q   <= '0;
                    paddr_q  <= vaddr;
                    err_q    <= ctrl[EN_BIT] && (ctrl[SUPV_BIT] || ctrl[FCL_BIT]);
                end
                ST_EVAL: begin
                    if (typ_q == DT_PAGE) begin
                        paddr_q <= merged;
                    end else if (!walk_go) begin
                        err_q <= 1'b1;
                    end else begin
                        rd_addr_q <= next_addr;
                        desc_q    <= next_addr;
                        pos_q     <= pos_q + POS_W'(cur_w);
                        level_q   <= level_q + 1'b1;
                    end
                end
                ST_RD_SHORT: if (mem_ack) begin
                    ptr_q    <= mem_rdata;
                    typ_q    <= desc_type_e'(mem_rdata[1:0]);
                    lim_en_q <= 1'b0;
                end
                ST_RD_HI: if (mem_ack) begin
                    typ_q    <= desc_type_e'(mem_rdata[1:0]);
                    lim_q    <= mem_rdata[31:32-IDX_W];
                    lim_en_q <= 1'b1;
                end
                ST_RD_LO: if (mem_ack) ptr_q <= mem_rdata;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_RD_SHORT) || (state_q == ST_RD_HI) ||
                    (state_q == ST_RD_LO);
        mem_addr  = (state_q == ST_RD_LO) ? (rd_addr_q + 32'd4) : rd_addr_q;
        done      = (state_q == ST_DONE);
        paddr     = paddr_q;
        desc_addr = desc_q;
        err       = err_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        idle,
    input logic [31:0] vaddr,
    input logic [31:0] ctrl,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic [31:0] paddr,
    input logic [31:0] desc_addr,
    input logic        err,
    input logic        done
);
    // R1
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && !ctrl[31]) |=>
            (done && !err && !mem_req && paddr == $past(vaddr) && desc_addr == 32'd0));

    // R2
    mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && ctrl[31] && (ctrl[25] || ctrl[24])) |=> (done && err && !mem_req));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R10
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

bind ptw_walker ptw_walker_chk i_ptw_walker_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(state_q == ST_IDLE),
    .vaddr(vaddr), .ctrl(ctrl), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .paddr(paddr), .desc_addr(desc_addr), .err(err),
    .done(done)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0, ctrl = '0, mem_rdata = '0;
    logic [63:0] root = '0;
    logic        mem_ack = 1'b0;
    logic        mem_req, done, err;
    logic [31:0] mem_addr, paddr, desc_addr;

    typedef struct {
        logic [31:0] pa;
        logic [31:0] da;
        logic        er;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] mem [1024];
    int checks = 0, errors = 0, results_seen = 0, rd_count = 0, wait_cnt = 0;

    always #2.5 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .ctrl(ctrl),
        .root(root), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .paddr(paddr),
        .desc_addr(desc_addr), .err(err), .done(done)
    );

    // memory model: acknowledges after two waiting cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack  = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                wait_cnt++;
                if (wait_cnt >= 2) begin
                    mem_rdata = mem[mem_addr[11:2]];
                    mem_ack   = 1'b1;
                    rd_count++;
                end
            end
        end
    end

    // monitor: compares each result against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected done: done=1 expected 0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (err !== e.er) begin
                        errors++;
                        $display("FAIL %s err: got %0b expected %0b", e.tag, err, e.er);
                    end
                    if (!e.er) begin
                        checks++;
                        if (paddr !== e.pa) begin
                            errors++;
                            $display("FAIL %s paddr: got %h expected %h", e.tag, paddr, e.pa);
                        end
                        checks++;
                        if (desc_addr !== e.da) begin
                            errors++;
                            $display("FAIL %s desc_addr: got %h expected %h", e.tag, desc_addr, e.da);
                        end
                    end
                end
                results_seen++;
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] cf,
                            input logic [63:0] rt, input logic [31:0] epa,
                            input logic [31:0] eda, input logic eer,
                            input string tag, input bit poke);
        exp_t e;
        int target;
        e.pa = epa; e.da = eda; e.er = eer; e.tag = tag;
        exp_q.push_back(e);
        target = results_seen + 1;
        @(negedge clk);
        vaddr = va; ctrl = cf; root = rt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; ctrl = 32'h0; vaddr = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0;
        end
        while (results_seen < target) @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog: done=0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rd_before;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[32'h10C >> 2] = 32'h0000_0202;
        mem[32'h228 >> 2] = 32'h5500_0001;
        mem[32'h114 >> 2] = 32'h0000_0202;
        mem[32'h200 >> 2] = 32'h0000_0302;
        mem[32'h328 >> 2] = 32'h8003_0002;
        mem[32'h32C >> 2] = 32'h0000_0408;
        mem[32'h414 >> 2] = 32'hFED0_0001;
        mem[32'h320 >> 2] = 32'h0000_0001;
        mem[32'h324 >> 2] = 32'h7000_0000;
        mem[32'h504 >> 2] = 32'h0000_0602;
        mem[32'h608 >> 2] = 32'h0000_0702;
        mem[32'h70C >> 2] = 32'h0000_0802;
        mem[32'h800 >> 2] = 32'h9900_0001;
        mem[32'h804 >> 2] = 32'h0000_0902;

        repeat (3) @(negedge clk);
        // reset state
        check(done === 1'b0 && mem_req === 1'b0 && err === 1'b0,
              "R10 reset outputs", int'(done) + int'(mem_req) + int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: translation off, including with the mode bits set
        rd_before = rd_count;
        run_walk(32'hDEAD_BEEF, 32'h0000_4400, 64'h7FFF_0002_0000_0100,
                 32'hDEAD_BEEF, 32'h0, 1'b0, "R1 off", 0);
        run_walk(32'h1234_0000, 32'h0300_0000, 64'h0,
                 32'h1234_0000, 32'h0, 1'b0, "R1 off ignores mode", 0);
        check(rd_count == rd_before, "R1 no reads", rd_count - rd_before, 0);

        // R2: forbidden mode bits
        rd_before = rd_count;
        run_walk(32'h0, 32'h8200_4400, 64'h7FFF_0002_0000_0100, 32'h0, 32'h0, 1'b1, "R2 bit25", 0);
        run_walk(32'h0, 32'h8100_4400, 64'h7FFF_0002_0000_0100, 32'h0, 32'h0, 1'b1, "R2 bit24", 0);
        check(rd_count == rd_before, "R2 no reads", rd_count - rd_before, 0);

        // R8 R7 R11: root is a page, skip 8 bits
        run_walk(32'h1234_5678, 32'h8008_0000, 64'h0000_0001_ABC0_0000,
                 32'hAB34_5678, 32'h0, 1'b0, "R8 R7 R11 root page", 0);

        // R3 R5 R7: two short levels
        run_walk(32'h3A00_0123, 32'h8000_4400, 64'h7FFF_0002_0000_0100,
                 32'h5500_0123, 32'h228, 1'b0, "R3 R5 short walk", 0);

        // R4: invalid descriptor
        run_walk(32'h4000_0000, 32'h8000_4400, 64'h7FFF_0002_0000_0100,
                 32'h0, 32'h0, 1'b1, "R4 invalid type", 0);

        // R9: table pointer at a zero-width level
        run_walk(32'h5000_0000, 32'h8000_4400, 64'h7FFF_0002_0000_0100,
                 32'h0, 32'h0, 1'b1, "R9 zero width", 0);

        // R3 R5 R6: skip 4, long then short, lower limit satisfied
        run_walk(32'h0A5F_F00D, 32'h8004_3500, 64'h0007_0003_0000_0300,
                 32'hFEDF_F00D, 32'h414, 1'b0, "R3 R5 R6 long walk", 0);

        // R6: lower limit violated at level 2
        run_walk(32'h0A2F_F00D, 32'h8004_3500, 64'h0007_0003_0000_0300,
                 32'h0, 32'h0, 1'b1, "R6 lower limit", 0);

        // R8 R6: root upper limit 4, index 5 fails, index 4 passes
        run_walk(32'h0A5F_F00D, 32'h8004_3500, 64'h0004_0003_0000_0300,
                 32'h0, 32'h0, 1'b1, "R8 R6 root upper limit", 0);
        run_walk(32'h0812_3456, 32'h8004_3500, 64'h0004_0003_0000_0300,
                 32'h7012_3456, 32'h320, 1'b0, "R8 R6 R11 limit equal long page", 0);

        // R3 R10: four short levels with a stray start mid-walk
        run_walk(32'h6C00_0ABC, 32'h8000_2222, 64'h7FFF_0002_0000_0500,
                 32'h9900_0ABC, 32'h800, 1'b0, "R3 R10 four levels", 1);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10 stray start ignored", exp_q.size(), 0);

        // R9: table pointer after the fourth level
        run_walk(32'h6D00_0ABC, 32'h8000_2222, 64'h7FFF_0002_0000_0500,
                 32'h0, 32'h0, 1'b1, "R9 past four levels", 0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule